// File: doc/BRIEF.md
# Transition Strobe Encoder with Level Refresh

This block is the sending half of a logic channel that crosses a barrier as short strobes instead of a level. It samples one asynchronous logic input, brings it into the clock domain through a flop chain, and turns each change of the settled level into a one-cycle strobe. A change to high raises the set strobe, and a change to low raises the clear strobe. A receiver built from a set/reset latch then rebuilds the level.

A latch fed only by edges can lose its state. So when the input holds still for a programmed number of cycles, the block sends a refresh strobe on the line that matches the present level. After that it repeats the refresh at a programmed period for as long as the input stays quiet. Any new transition restarts the quiet interval, so refresh strobes never land among active data. A channel-enable input silences both strobes and holds the timer at zero.

Top module: `edge_pulse_tx`

## Requirements
- R1: A low-to-high change of `sig_i` that is held raises `pulse_set_o` for one cycle. The strobe is visible after the third rising clock edge at which the new level is sampled: two synchroniser stages, then the output register.
- R2: A high-to-low change of `sig_i` that is held raises `pulse_clr_o` for one cycle, with the same three-edge latency as R1.
- R3: Every strobe lasts exactly one clock cycle. Neither output is high in two consecutive cycles.
- R4: `pulse_set_o` and `pulse_clr_o` are never high in the same cycle.
- R5: Once a strobe has been sent and the synchronised input stays unchanged, a refresh strobe follows exactly IDLE_CYCLES cycles later. It goes on `pulse_set_o` if the level is 1 and on `pulse_clr_o` if the level is 0.
- R6: After a refresh, further refresh strobes of the same polarity follow every REFRESH_CYCLES cycles while the input stays static.
- R7: A transition restarts the quiet interval. After the last transition strobe, the next refresh comes IDLE_CYCLES cycles after that strobe, and never earlier.
- R8: While `chan_en_i` is low, no strobe is emitted and the timer is held at zero. Level changes made while disabled produce no strobe once the channel is enabled again. The first refresh is visible IDLE_CYCLES cycles after the first enabled clock edge.
- R9: While `rst` is high at a clock edge, both outputs are low on the next cycle. Reset clears the synchroniser and sets the tracked level to 0.
- R10: A high input that is sampled at just one clock edge still produces a set strobe followed in the very next cycle by a clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Asynchronous logic input to encode |
| chan_en_i | input | 1 | Channel enable; low silences the strobes |
| pulse_set_o | output | 1 | One-cycle strobe for a rise or a high-level refresh |
| pulse_clr_o | output | 1 | One-cycle strobe for a fall or a low-level refresh |

## Verification
The hardest case to reach from the ports is a transition that arrives just before a refresh was due. There the edge strobe must win and the refresh schedule must move. The stimulus toggles the input a few cycles short of the idle interval, several times in a row, each time just after a strobe is seen. It then checks that every gap equals the synchroniser latency and that the later refresh is timed from the last strobe. A second hard case is the one-cycle input pulse, which makes set and clear strobes land back to back. A behavioural model checks every cycle besides the directed cases.

// File: rtl/epx_pkg.sv
package epx_pkg;
  typedef enum logic {
    TMR_QUIET   = 1'b0,
    TMR_REFRESH = 1'b1
  } tmr_phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/epx_sync.sv
module epx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/epx_idle_timer.sv
module epx_idle_timer
  import epx_pkg::*;
#(
  parameter int IDLE_CYCLES    = 100,
  parameter int REFRESH_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic fire
);
  localparam int CW = $clog2(max2(IDLE_CYCLES, REFRESH_CYCLES) + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;
  tmr_phase_t    phase;

  always_comb begin
    if (phase == TMR_REFRESH) limit_m1 = CW'(REFRESH_CYCLES - 1);
    else                      limit_m1 = CW'(IDLE_CYCLES - 1);
  end

  assign fire = en && !restart && (cnt == limit_m1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      phase <= TMR_QUIET;
    end else if (restart) begin
      cnt   <= '0;
      phase <= TMR_QUIET;
    end else if (fire) begin
      cnt   <= '0;
      phase <= TMR_REFRESH;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/epx_pulse_gen.sv
module epx_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lvl_i,
  input  logic fire_i,
  output logic change_o,
  output logic trk_o,
  output logic set_o,
  output logic clr_o
);
  logic trk;

  assign change_o = lvl_i ^ trk;
  assign trk_o    = trk;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk   <= 1'b0;
      set_o <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      trk <= lvl_i;
      if (!en) begin
        set_o <= 1'b0;
        clr_o <= 1'b0;
      end else if (change_o) begin
        set_o <= lvl_i;
        clr_o <= !lvl_i;
      end else begin
        set_o <= fire_i && trk;
        clr_o <= fire_i && !trk;
      end
    end
  end
endmodule

// File: rtl/edge_pulse_tx.sv
module edge_pulse_tx #(
  parameter int SYNC_STAGES    = 2,
  parameter int IDLE_CYCLES    = 100,
  parameter int REFRESH_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  input  logic chan_en_i,
  output logic pulse_set_o,
  output logic pulse_clr_o
);
  logic sync_lvl;
  logic trk_lvl;
  logic lvl_change;
  logic refresh_fire;

  epx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (sig_i),
    .sync_o  (sync_lvl)
  );

  epx_idle_timer #(
    .IDLE_CYCLES    (IDLE_CYCLES),
    .REFRESH_CYCLES (REFRESH_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      (chan_en_i),
    .restart (lvl_change),
    .fire    (refresh_fire)
  );

  epx_pulse_gen u_pgen (
    .clk      (clk),
    .rst      (rst),
    .en       (chan_en_i),
    .lvl_i    (sync_lvl),
    .fire_i   (refresh_fire),
    .change_o (lvl_change),
    .trk_o    (trk_lvl),
    .set_o    (pulse_set_o),
    .clr_o    (pulse_clr_o)
  );
endmodule

// File: rtl/epx_checker.sv
module epx_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic sync_lvl,
  input logic trk_lvl,
  input logic set_p,
  input logic clr_p
);
  assert_rise_R1: assert property (@(posedge clk) disable iff (rst)
    en && sync_lvl && !trk_lvl |=> set_p);

  assert_fall_R2: assert property (@(posedge clk) disable iff (rst)
    en && !sync_lvl && trk_lvl |=> clr_p);

  assert_set_width_R3: assert property (@(posedge clk) disable iff (rst)
    set_p |=> !set_p);

  assert_clr_width_R3: assert property (@(posedge clk) disable iff (rst)
    clr_p |=> !clr_p);

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(set_p && clr_p));

  assert_silent_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !set_p && !clr_p);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> !set_p && !clr_p);
endmodule

bind edge_pulse_tx epx_checker u_epx_checker (
  .clk      (clk),
  .rst      (rst),
  .en       (chan_en_i),
  .sync_lvl (sync_lvl),
  .trk_lvl  (trk_lvl),
  .set_p    (pulse_set_o),
  .clr_p    (pulse_clr_o)
);

// File: tb/test_edge_pulse_tx.sv
`timescale 1ns/1ps
module test_edge_pulse_tx;
  localparam int IDLE = 12;
  localparam int REFR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic en  = 1'b0;
  logic set_p, clr_p;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  edge_pulse_tx #(
    .SYNC_STAGES    (2),
    .IDLE_CYCLES    (IDLE),
    .REFRESH_CYCLES (REFR)
  ) i_edge_pulse_tx (
    .clk         (clk),
    .rst         (rst),
    .sig_i       (din),
    .chan_en_i   (en),
    .pulse_set_o (set_p),
    .pulse_clr_o (clr_p)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit sq[$] = '{1'b0, 1'b0};
  bit m_lvl = 0;
  bit m_rep = 0;
  int m_cnt = 0;
  bit e_set = 0, e_clr = 0;

  always @(posedge clk) begin
    if (rst) begin
      sq = '{1'b0, 1'b0};
      m_lvl = 0; m_rep = 0; m_cnt = 0; e_set = 0; e_clr = 0;
    end else begin
      bit cur;
      int lim;
      cur = sq[1];
      lim = m_rep ? REFR : IDLE;
      if (!en) begin
        e_set = 0; e_clr = 0; m_cnt = 0; m_rep = 0;
      end else if (cur != m_lvl) begin
        e_set = cur; e_clr = !cur; m_cnt = 0; m_rep = 0;
      end else if (m_cnt == lim - 1) begin
        e_set = m_lvl; e_clr = !m_lvl; m_cnt = 0; m_rep = 1;
      end else begin
        e_set = 0; e_clr = 0; m_cnt++;
      end
      m_lvl = cur;
      void'(sq.pop_back());
      sq.push_front(din);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(set_p == e_set, "R1", "model set strobe", set_p, e_set);
      chk(clr_p == e_clr, "R2", "model clear strobe", clr_p, e_clr);
      chk(!(set_p && clr_p), "R4", "both strobes high", 1, 0);
    end
  end

  // waits from the current negedge until a strobe shows; n = negedges waited
  task automatic wait_pulse(input int maxn, output int n, output bit s, output bit c);
    n = 0; s = 0; c = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk);
      if (set_p || clr_p) begin
        n = i; s = set_p; c = clr_p;
        return;
      end
    end
  endtask

  initial begin
    int n;
    bit s, c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!set_p && !clr_p, "R9", "outputs after reset", {set_p, clr_p}, 0);

    // R8: changes while disabled are silent
    din = 1'b1;
    wait_pulse(10, n, s, c);
    chk(n == 0, "R8", "strobe while disabled", n, 0);
    en = 1'b1;
    wait_pulse(40, n, s, c);
    chk(n == IDLE, "R8", "first refresh after enable", n, IDLE);
    chk(s && !c, "R5", "refresh polarity high", {s, c}, 2);
    wait_pulse(40, n, s, c);
    chk(n == REFR && s, "R6", "refresh period 1", n, REFR);
    wait_pulse(40, n, s, c);
    chk(n == REFR && s, "R6", "refresh period 2", n, REFR);

    // R2 falling edge
    din = 1'b0;
    wait_pulse(40, n, s, c);
    chk(n == 3 && c && !s, "R2", "fall latency", n, 3);
    @(negedge clk);
    chk(!clr_p, "R3", "clear width", clr_p, 0);
    wait_pulse(40, n, s, c);
    chk(n == IDLE - 1 && c, "R5", "low refresh after idle", n + 1, IDLE);

    // R1 rising edge
    din = 1'b1;
    wait_pulse(40, n, s, c);
    chk(n == 3 && s && !c, "R1", "rise latency", n, 3);
    @(negedge clk);
    chk(!set_p, "R3", "set width", set_p, 0);

    // R7: toggles just inside the idle interval
    for (int k = 0; k < 4; k++) begin
      repeat (6) @(negedge clk);
      din = ~din;
      wait_pulse(40, n, s, c);
      chk(n == 3, "R7", "toggle strobe timing", n, 3);
      chk(s == din && c == !din, "R7", "toggle strobe polarity", s, din);
    end
    wait_pulse(40, n, s, c);
    chk(n == IDLE && s == din, "R7", "refresh timed from last strobe", n, IDLE);

    // R10 one-cycle input pulse
    din = ~din;
    @(negedge clk);
    din = ~din;
    wait_pulse(40, n, s, c);
    chk(n == 2 && s == !din, "R10", "leading strobe", n, 2);
    @(negedge clk);
    chk(set_p == din && clr_p == !din, "R10", "trailing strobe next cycle", set_p, din);

    // R8: disable mid-stream then recheck silence
    en = 1'b0;
    din = ~din;
    wait_pulse(30, n, s, c);
    chk(n == 0, "R8", "silent when disabled", n, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule